// File: doc/BRIEF.md
# Selectable-Width Interrupt Down-Counter

This block is an interval timer that runs on the CPU clock and raises an interrupt request. Software loads a 16-bit reload value one 4-bit slice at a time. A working counter counts down by one on each CPU clock enable while counting is switched on. A control write chooses how many low bits of the counter are watched for a wrap: 4, 8, 12 or 16. When those watched bits go from all zeros to all ones, the block raises its interrupt and loads the counter from the reload value, so it repeats at a fixed period.

The CPU side is a single-cycle write strobe with a group select, a slice sub-address and 4 data bits. No write is ever refused, so there is no handshake or back-pressure. Every pin is a plain strobe or level. The interrupt is a level output. It stays high until software writes one of the two acknowledge registers.

Top module: `wrap_timer`

## Requirements
- R1: After reset the interrupt is low, the counter and the reload value both hold 0xFFFF, the watched width is 16 bits and counting is paused. No clock enable raises the interrupt until counting is switched on.
- R2: A write with `wr_grp`=0 stores `wr_data` into one 4-bit slice of the reload value: sub-address k sets bits 4k+3..4k. The other slices keep their values.
- R3: A write with `wr_grp`=1 and sub-address 0 (load-acknowledge) clears the interrupt and copies the reload value into the counter.
- R4: A write with `wr_grp`=1 and sub-address 1 (control-acknowledge) clears the interrupt. It switches counting on when `wr_data[0]`=1 and pauses it when `wr_data[0]`=0.
- R5: The control-acknowledge write picks the width by priority: `wr_data[3]`=1 gives 4 bits, else `wr_data[2]`=1 gives 8, else `wr_data[1]`=1 gives 12, else 16.
- R6: While counting is on, the counter drops by one in each cycle with `cpu_ce`=1. With `cpu_ce`=0 or with counting paused, it holds its value.
- R7: When a counting cycle finds the watched bits all zero, the interrupt goes high in the next cycle. In that cycle the counter is loaded from the reload value and does not take the decremented value.
- R8: Once high, the interrupt stays high through further wraps until one of the two acknowledge writes.
- R9: An acknowledge write wins over a wrap in the same cycle. The interrupt is cleared. The counter is loaded (load-acknowledge) or held (control-acknowledge), and the cycle counts no decrement.
- R10: Changing the width does not change the stored counter value. It only changes which bits are watched for a wrap.
- R11: Writes with `wr_grp`=1 and sub-address 2 or 3 have no effect on the interrupt or the counter.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_ce | input | 1 | CPU clock enable, one per counted cycle |
| wr_en | input | 1 | Register write strobe, one cycle per write |
| wr_grp | input | 1 | 0 = reload slices, 1 = acknowledge/command group |
| wr_sub | input | 2 | Sub-address within the group |
| wr_data | input | 4 | Write data |
| irq | output | 1 | Interrupt request level |

## Verification
The properties assume that `wr_grp`, `wr_sub` and `wr_data` carry known values whenever `wr_en` is high. They also assume at most one register write per cycle, and that `cpu_ce` may take any value in any cycle, including the same cycle as a write. The bench drives every input with defined values on the falling edge and offers one write per step, so it cannot break that rule. Its random phase mixes writes freely with clock-enable gaps, so acknowledge writes regularly land on wrap cycles.

// File: rtl/wt_pkg.sv
package wt_pkg;
  // Write groups
  typedef enum logic {
    GRP_RELOAD = 1'b0,
    GRP_CMD    = 1'b1
  } wt_grp_e;

  // Sub-addresses inside the command group
  localparam int unsigned SUB_ACK_LOAD = 0;
  localparam int unsigned SUB_ACK_CTRL = 1;

  // Decoded acknowledge strobes
  typedef struct packed {
    logic load;
    logic ctrl;
  } wt_ack_t;
endpackage

// File: rtl/wt_regs.sv
module wt_regs
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SLICE_W = 4,
  localparam int unsigned NSLICE = CNT_W / SLICE_W,
  localparam int unsigned SUB_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  localparam int unsigned AW     = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic               wr_grp,
  input  logic [SUB_W-1:0]   wr_sub,
  input  logic [SLICE_W-1:0] wr_data,
  output logic [CNT_W-1:0]   reload_q,
  output logic               run_en,
  output logic [AW-1:0]      act_m1,
  output wt_ack_t            ack
);
  logic to_reload;
  logic [AW-1:0] sel_m1;

  assign to_reload = wr_en && (wr_grp == GRP_RELOAD);
  assign ack.load  = wr_en && (wr_grp == GRP_CMD) && (wr_sub == SUB_W'(SUB_ACK_LOAD));
  assign ack.ctrl  = wr_en && (wr_grp == GRP_CMD) && (wr_sub == SUB_W'(SUB_ACK_CTRL));

  // One register per reload slice
  for (genvar k = 0; k < NSLICE; k++) begin : g_slice
    always_ff @(posedge clk) begin
      if (!rst_n)
        reload_q[k*SLICE_W +: SLICE_W] <= '1;
      else if (to_reload && (wr_sub == SUB_W'(k)))
        reload_q[k*SLICE_W +: SLICE_W] <= wr_data;
    end
  end

  // Priority width select: higher data bit -> fewer active slices
  always_comb begin
    sel_m1 = AW'(NSLICE - 1);
    for (int i = 1; i < int'(NSLICE); i++)
      if (wr_data[i]) sel_m1 = AW'(int'(NSLICE) - 1 - i);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      run_en <= 1'b0;
      act_m1 <= AW'(NSLICE - 1);
    end else if (ack.ctrl) begin
      run_en <= wr_data[0];
      act_m1 <= sel_m1;
    end
  end
endmodule

// File: rtl/wt_counter.sv
module wt_counter
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SLICE_W = 4,
  localparam int unsigned NSLICE = CNT_W / SLICE_W,
  localparam int unsigned AW     = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tick,
  input  logic             run_en,
  input  logic [AW-1:0]    act_m1,
  input  logic [CNT_W-1:0] reload_q,
  input  wt_ack_t          ack,
  output logic [CNT_W-1:0] cnt_q,
  output logic             wrap
);
  logic [CNT_W-1:0] watch_mask;
  logic             counting;

  // Slice j is watched when j <= act_m1
  for (genvar j = 0; j < NSLICE; j++) begin : g_mask
    assign watch_mask[j*SLICE_W +: SLICE_W] = {SLICE_W{AW'(j) <= act_m1}};
  end

  assign counting = tick && run_en && !ack.load && !ack.ctrl;
  assign wrap     = counting && ((cnt_q & watch_mask) == '0);

  always_ff @(posedge clk) begin
    if (!rst_n)
      cnt_q <= '1;
    else if (ack.load)
      cnt_q <= reload_q;
    else if (wrap)
      cnt_q <= reload_q;
    else if (counting)
      cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wt_irq.sv
module wt_irq
  import wt_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    wrap,
  input  wt_ack_t ack,
  output logic    irq_q
);
  always_ff @(posedge clk) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else if (ack.load || ack.ctrl)
      irq_q <= 1'b0;
    else if (wrap)
      irq_q <= 1'b1;
  end
endmodule

// File: rtl/wrap_timer.sv
module wrap_timer
  import wt_pkg::*;
#(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SLICE_W = 4,
  localparam int unsigned NSLICE = CNT_W / SLICE_W,
  localparam int unsigned SUB_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  localparam int unsigned AW     = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cpu_ce,
  input  logic               wr_en,
  input  logic               wr_grp,
  input  logic [SUB_W-1:0]   wr_sub,
  input  logic [SLICE_W-1:0] wr_data,
  output logic               irq
);
  logic [CNT_W-1:0] reload_q;
  logic [CNT_W-1:0] cnt_q;
  logic             run_en;
  logic [AW-1:0]    act_m1;
  logic             wrap;
  wt_ack_t          ack;

  wt_regs #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_grp(wr_grp),
    .wr_sub(wr_sub), .wr_data(wr_data), .reload_q(reload_q),
    .run_en(run_en), .act_m1(act_m1), .ack(ack)
  );

  wt_counter #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_cnt (
    .clk(clk), .rst_n(rst_n), .tick(cpu_ce), .run_en(run_en),
    .act_m1(act_m1), .reload_q(reload_q), .ack(ack),
    .cnt_q(cnt_q), .wrap(wrap)
  );

  wt_irq u_irq (
    .clk(clk), .rst_n(rst_n), .wrap(wrap), .ack(ack), .irq_q(irq)
  );
endmodule

// File: rtl/wt_checker.sv
module wt_checker #(
  parameter int unsigned CNT_W   = 16,
  parameter int unsigned SLICE_W = 4,
  localparam int unsigned NSLICE = CNT_W / SLICE_W,
  localparam int unsigned SUB_W  = (NSLICE > 1) ? $clog2(NSLICE) : 1,
  localparam int unsigned AW     = (NSLICE > 1) ? $clog2(NSLICE) : 1
) (
  input logic               clk,
  input logic               rst_n,
  input logic               cpu_ce,
  input logic               wr_en,
  input logic               wr_grp,
  input logic [SUB_W-1:0]   wr_sub,
  input logic [SLICE_W-1:0] wr_data,
  input logic               irq,
  input logic [CNT_W-1:0]   cnt,
  input logic [CNT_W-1:0]   reload,
  input logic               run_en,
  input logic [AW-1:0]      act_m1
);
  logic [CNT_W-1:0] chk_mask;
  logic a_load, a_ctrl, any_ack, cmd_other, step;

  always_comb begin
    chk_mask = '0;
    for (int b = 0; b < int'(CNT_W); b++)
      if (b < (int'(act_m1) + 1) * int'(SLICE_W)) chk_mask[b] = 1'b1;
  end

  assign a_load    = wr_en && wr_grp && (wr_sub == SUB_W'(0));
  assign a_ctrl    = wr_en && wr_grp && (wr_sub == SUB_W'(1));
  assign any_ack   = a_load || a_ctrl;
  assign cmd_other = wr_en && wr_grp && !any_ack;
  assign step      = cpu_ce && run_en && !any_ack;

  function automatic logic [SLICE_W-1:0] slice_of(input logic [CNT_W-1:0] v,
                                                  input logic [SUB_W-1:0] s);
    slice_of = SLICE_W'(v >> (int'(s) * int'(SLICE_W)));
  endfunction

  assert_reload_slice_R2: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && !wr_grp |=> slice_of(reload, $past(wr_sub)) == $past(wr_data));

  assert_load_ack_R3: assert property (@(posedge clk) disable iff (!rst_n)
    a_load |=> !irq && cnt == $past(reload));

  assert_ctrl_ack_R4: assert property (@(posedge clk) disable iff (!rst_n)
    a_ctrl |=> !irq && run_en == $past(wr_data[0]));

  assert_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !a_load && !step |=> $stable(cnt));

  assert_decrement_R6: assert property (@(posedge clk) disable iff (!rst_n)
    step && ((cnt & chk_mask) != '0) |=> cnt == $past(cnt) - 1'b1);

  assert_wrap_R7: assert property (@(posedge clk) disable iff (!rst_n)
    step && ((cnt & chk_mask) == '0) |=> irq && cnt == $past(reload));

  assert_irq_sticky_R8: assert property (@(posedge clk) disable iff (!rst_n)
    irq && !any_ack |=> irq);

  assert_width_keeps_count_R10: assert property (@(posedge clk) disable iff (!rst_n)
    a_ctrl |=> cnt == $past(cnt));

  assert_other_cmd_ignored_R11: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_other && !(cpu_ce && run_en) |=> $stable(cnt) && $stable(irq));
endmodule

bind wrap_timer wt_checker #(.CNT_W(CNT_W), .SLICE_W(SLICE_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en), .wr_grp(wr_grp),
  .wr_sub(wr_sub), .wr_data(wr_data), .irq(irq), .cnt(cnt_q),
  .reload(reload_q), .run_en(run_en), .act_m1(act_m1)
);

// File: tb/tb_wrap_timer.sv
`timescale 1ns/1ps
module tb_wrap_timer;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cpu_ce = 1'b0;
  logic       wr_en = 1'b0;
  logic       wr_grp = 1'b0;
  logic [1:0] wr_sub = '0;
  logic [3:0] wr_data = '0;
  logic       irq;

  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;
  string cur_tag = "R1";

  // Reference model state
  logic [15:0] m_cnt, m_rel;
  logic        m_en, m_irq;
  int          m_w;

  always #2.5 clk = ~clk;

  wrap_timer dut (.clk(clk), .rst_n(rst_n), .cpu_ce(cpu_ce), .wr_en(wr_en),
                  .wr_grp(wr_grp), .wr_sub(wr_sub), .wr_data(wr_data), .irq(irq));

  function automatic int width_of(input logic [3:0] d);
    if (d[3]) return 4;
    if (d[2]) return 8;
    if (d[1]) return 12;
    return 16;
  endfunction

  function automatic logic [15:0] mask_of(input int w);
    logic [31:0] one = 32'd1;
    return 16'((one << w) - 1);
  endfunction

  always @(posedge clk) begin
    logic [15:0] old_rel;
    if (!rst_n) begin
      m_cnt = 16'hFFFF; m_rel = 16'hFFFF; m_en = 1'b0; m_irq = 1'b0; m_w = 16;
    end else begin
      old_rel = m_rel;
      if (wr_en && !wr_grp) m_rel[wr_sub*4 +: 4] = wr_data;
      if (wr_en && wr_grp && wr_sub == 2'd0) begin
        m_irq = 1'b0; m_cnt = old_rel;
      end else if (wr_en && wr_grp && wr_sub == 2'd1) begin
        m_irq = 1'b0; m_en = wr_data[0]; m_w = width_of(wr_data);
      end else if (cpu_ce && m_en) begin
        if ((m_cnt & mask_of(m_w)) == 16'h0) begin
          m_irq = 1'b1; m_cnt = old_rel;
        end else m_cnt = m_cnt - 16'd1;
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: irq actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  // Every cycle: compare against the model, away from the active edge
  always @(negedge clk) if (rst_n && !done) chk(irq, m_irq, cur_tag);

  task automatic step(input logic we, input logic grp, input logic [1:0] sub,
                      input logic [3:0] d, input logic ce);
    @(negedge clk);
    wr_en = we; wr_grp = grp; wr_sub = sub; wr_data = d; cpu_ce = ce;
    @(posedge clk);
    #1;
  endtask

  task automatic ticks(input int n, input logic ce);
    for (int i = 0; i < n; i++) step(1'b0, 1'b0, 2'd0, 4'd0, ce);
  endtask

  task automatic summary;
    $display("  [TB] %0d tests run, %0d failed", n_checks, n_fail);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=running expected=finished");
      summary();
      $finish;
    end
  end

  initial begin
    int seed_r;
    seed_r = $urandom(32'd2024);
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    chk(irq, 1'b0, "R1");

    // R1: paused at power-on, then counter starts at 0xFFFF
    cur_tag = "R1";
    ticks(20, 1'b1);
    chk(irq, 1'b0, "R1");
    step(1'b1, 1'b1, 2'd1, 4'h9, 1'b0);       // enable, 4-bit width
    ticks(15, 1'b1);
    chk(irq, 1'b0, "R1");
    ticks(1, 1'b1);
    chk(irq, 1'b1, "R1");
    step(1'b1, 1'b1, 2'd0, 4'h0, 1'b0);       // load-ack: reload is 0xFFFF
    chk(irq, 1'b0, "R3");
    ticks(16, 1'b1);
    chk(irq, 1'b1, "R1");

    // R2: build reload 0x0003 slice by slice
    cur_tag = "R2";
    step(1'b1, 1'b0, 2'd0, 4'h3, 1'b0);
    step(1'b1, 1'b0, 2'd1, 4'h0, 1'b0);
    step(1'b1, 1'b0, 2'd2, 4'h0, 1'b0);
    step(1'b1, 1'b0, 2'd3, 4'h0, 1'b0);
    step(1'b1, 1'b1, 2'd0, 4'h0, 1'b0);
    chk(irq, 1'b0, "R3");
    cur_tag = "R7";
    ticks(3, 1'b1);
    chk(irq, 1'b0, "R7");
    ticks(1, 1'b1);
    chk(irq, 1'b1, "R7");
    cur_tag = "R8";
    ticks(4, 1'b1);                            // second wrap, counter back to 3
    chk(irq, 1'b1, "R8");

    // R11: other command sub-addresses leave everything alone
    cur_tag = "R11";
    step(1'b1, 1'b1, 2'd2, 4'hF, 1'b0);
    step(1'b1, 1'b1, 2'd3, 4'hF, 1'b0);
    chk(irq, 1'b1, "R11");

    // R4 and R9: control write with a tick clears irq and holds counter
    cur_tag = "R4";
    step(1'b1, 1'b1, 2'd1, 4'h9, 1'b1);
    chk(irq, 1'b0, "R4");
    cur_tag = "R9";
    ticks(3, 1'b1);                            // 3 -> 0
    chk(irq, 1'b0, "R9");
    step(1'b1, 1'b1, 2'd1, 4'h9, 1'b1);        // ack lands on wrap cycle
    chk(irq, 1'b0, "R9");
    ticks(1, 1'b1);
    chk(irq, 1'b1, "R9");

    // R6: no counting without the clock enable
    cur_tag = "R6";
    step(1'b1, 1'b1, 2'd0, 4'h0, 1'b1);
    ticks(10, 1'b0);
    ticks(3, 1'b1);
    chk(irq, 1'b0, "R6");
    ticks(1, 1'b1);
    chk(irq, 1'b1, "R6");

    // R5: priority width, reload 0x0103
    cur_tag = "R5";
    step(1'b1, 1'b0, 2'd2, 4'h1, 1'b0);
    step(1'b1, 1'b1, 2'd0, 4'h0, 1'b0);
    step(1'b1, 1'b1, 2'd1, 4'h7, 1'b0);        // bits 2 and 1 set: 8 wins
    ticks(4, 1'b1);
    chk(irq, 1'b1, "R5");
    step(1'b1, 1'b1, 2'd0, 4'h0, 1'b0);
    step(1'b1, 1'b1, 2'd1, 4'h3, 1'b0);        // 12 bits
    ticks(4, 1'b1);
    chk(irq, 1'b0, "R5");
    ticks(255, 1'b1);
    chk(irq, 1'b0, "R5");
    ticks(1, 1'b1);
    chk(irq, 1'b1, "R5");

    // R10: width change keeps the stored count
    cur_tag = "R10";
    step(1'b1, 1'b1, 2'd0, 4'h0, 1'b0);        // count 0x0103
    step(1'b1, 1'b1, 2'd1, 4'h9, 1'b0);        // 4 bits
    ticks(3, 1'b1);                            // count 0x0100
    step(1'b1, 1'b1, 2'd1, 4'h3, 1'b1);        // 12 bits, hold
    ticks(256, 1'b1);
    chk(irq, 1'b0, "R10");
    ticks(1, 1'b1);
    chk(irq, 1'b1, "R10");

    // Random phase against the model
    cur_tag = "R6";
    for (int i = 0; i < 4000; i++) begin
      logic we;
      we = ($urandom % 10) == 0;
      step(we, 1'($urandom), 2'($urandom), 4'($urandom), ($urandom % 4) != 0);
    end

    done = 1'b1;
    summary();
    $finish;
  end
endmodule